// File: doc/BRIEF.md
# Operand Addressing-Mode Resolver

This block turns a 6-bit operand selector into the place the operand lives: a register slot, a memory word address, or an inline constant. It is used by an instruction sequencer once per operand. Alongside the selector, the sequencer supplies a flag telling whether the selector belongs to the source-side operand ("a") or the destination-side operand ("b"). It also supplies its working program counter and stack pointer and the eight general-purpose register values. The resolver returns the located operand together with the program counter and stack pointer as they stand after the operand has been consumed.

Some selectors need an extension word that follows the instruction. The resolver fetches it through a combinational read port whose address is always the incoming program counter, and it advances the program counter by one when it consumes that word. The stack selector behaves differently on each side: on side a it is a pop (read at SP, then SP+1), and on side b it is a push (SP−1 first, then access at the new SP). Selectors of 0x20 and above carry a small constant inline and are legal only on side a. The block only locates the operand. Reading or writing the operand is left to the caller. A request is presented for one cycle on `req_valid`, and the registered result appears on the following clock edge with `res_valid` high.

Top module: `opnd_resolver`

## Requirements
- R1: Codes 0x00–0x07 give loc_kind 0 (register) with loc_value equal to code[2:0], writable 1, pc_out = pc_in and sp_out = sp_in.
- R2: Codes 0x08–0x0F give loc_kind 1 (memory) with loc_value equal to the value of general register code[2:0], writable 1, and PC and SP unchanged.
- R3: Codes 0x10–0x17 give loc_kind 1 with loc_value = (register code[2:0] + mem_rdata) mod 2^16, where mem_addr = pc_in. pc_out = pc_in + 1 mod 2^16 and SP is unchanged.
- R4: Code 0x18 on side a gives loc_kind 1 at address sp_in with sp_out = sp_in + 1. On side b it gives address sp_in − 1 with sp_out = sp_in − 1 (mod 2^16). PC is unchanged on both sides.
- R5: Code 0x19 gives loc_kind 1 at address sp_in with PC and SP unchanged. Code 0x1A gives loc_kind 1 at (sp_in + mem_rdata) mod 2^16 with pc_out = pc_in + 1.
- R6: Codes 0x1B, 0x1C and 0x1D give loc_kind 0 with loc_value 8, 9 and 10 (SP, PC, EX), writable 1, and PC and SP unchanged.
- R7: Code 0x1E gives loc_kind 1 at address mem_rdata. Code 0x1F gives loc_kind 1 at address pc_in. Both give pc_out = pc_in + 1.
- R8: Codes 0x20–0x3F on side a give loc_kind 2 (literal) with loc_value = (code − 0x21) mod 2^16, covering 0xFFFF up to 30. PC and SP are unchanged.
- R9: A literal location reports writable 0, so a write to it is discarded. Register and memory locations report writable 1.
- R10: Codes 0x20–0x3F on side b raise err, give loc_kind 2 with loc_value 0 and writable 0, and leave PC and SP unchanged. err is 0 for every other request.
- R11: Results are registered. They appear on the clock edge after a cycle with req_valid high, and res_valid is high only then. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Resolve request this cycle |
| op_code | input | 6 | Operand selector |
| is_a | input | 1 | 1 = side a operand, 0 = side b operand |
| pc_in | input | 16 | Working program counter |
| sp_in | input | 16 | Working stack pointer |
| gpr_flat | input | 128 | Eight general registers, register n at bits 16n+15:16n |
| mem_addr | output | 16 | Extension word read address (equals pc_in) |
| mem_rdata | input | 16 | Extension word, returned combinationally |
| res_valid | output | 1 | Result registers hold a fresh result |
| loc_kind | output | 2 | 0 register, 1 memory, 2 literal |
| loc_value | output | 16 | Register index, memory address or literal |
| writable | output | 1 | Location accepts a write |
| pc_out | output | 16 | Program counter after the operand |
| sp_out | output | 16 | Stack pointer after the operand |
| err | output | 1 | Illegal selector for side b |

## Verification
The hardest conditions to reach from the ports are the wrap-arounds. These are a push with SP at 0, a pop with SP at 0xFFFF, an extension-word fetch with the PC at 0xFFFF, and a register-plus-offset sum that carries out of 16 bits. The bench sweeps every selector on both sides under three machine states. It picks the PC, SP and register values so that each of those carries happens, and it drives the memory model with a data pattern that makes offset sums overflow. The illegal side-b literal range is covered in the same sweep.

// File: rtl/opnd_pkg.sv
// Shared constants and types for the operand resolver.
// Assumes a 16-bit machine word and a 6-bit operand selector.
package opnd_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 6;
    localparam int RIDX_W = 4;

    typedef enum logic [1:0] {
        LOC_REG = 2'd0,
        LOC_MEM = 2'd1,
        LOC_LIT = 2'd2
    } loc_kind_e;

    typedef enum logic [1:0] {
        BASE_ZERO = 2'd0,
        BASE_GPR  = 2'd1,
        BASE_SP   = 2'd2
    } base_sel_e;

    typedef struct packed {
        loc_kind_e          kind;
        base_sel_e          base;
        logic               uses_next;
        logic               sp_pre_dec;
        logic               sp_post_inc;
        logic               addr_is_pc;
        logic [RIDX_W-1:0]  reg_idx;
        logic [WORD_W-1:0]  lit;
        logic               illegal;
    } mode_t;
endpackage

// File: rtl/opnd_mode_decode.sv
// Classifies an operand selector into a mode record.
// Purely combinational; assumes the selector is exactly CODE_W bits.
module opnd_mode_decode
    import opnd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              is_a,
    output mode_t             mode
);
    localparam logic [WORD_W-1:0] LIT_BIAS = WORD_W'(33);
    localparam logic [RIDX_W-1:0] IDX_SP   = RIDX_W'(8);
    localparam logic [RIDX_W-1:0] IDX_PC   = RIDX_W'(9);
    localparam logic [RIDX_W-1:0] IDX_EX   = RIDX_W'(10);

    // Decode selector groups into location kind and address recipe.
    always_comb begin
        mode       = '0;
        mode.kind  = LOC_MEM;
        mode.base  = BASE_ZERO;
        if (code[5]) begin
            mode.kind = LOC_LIT;
            if (is_a) begin
                mode.lit = WORD_W'(code) - LIT_BIAS;
            end else begin
                mode.illegal = 1'b1;
            end
        end else begin
            case (code[4:3])
                2'd0: begin
                    mode.kind    = LOC_REG;
                    mode.reg_idx = RIDX_W'(code[2:0]);
                end
                2'd1: begin
                    mode.base    = BASE_GPR;
                    mode.reg_idx = RIDX_W'(code[2:0]);
                end
                2'd2: begin
                    mode.base      = BASE_GPR;
                    mode.reg_idx   = RIDX_W'(code[2:0]);
                    mode.uses_next = 1'b1;
                end
                default: begin
                    case (code[2:0])
                        3'd0: begin
                            mode.base        = BASE_SP;
                            mode.sp_pre_dec  = !is_a;
                            mode.sp_post_inc = is_a;
                        end
                        3'd1: mode.base = BASE_SP;
                        3'd2: begin
                            mode.base      = BASE_SP;
                            mode.uses_next = 1'b1;
                        end
                        3'd3: begin
                            mode.kind    = LOC_REG;
                            mode.reg_idx = IDX_SP;
                        end
                        3'd4: begin
                            mode.kind    = LOC_REG;
                            mode.reg_idx = IDX_PC;
                        end
                        3'd5: begin
                            mode.kind    = LOC_REG;
                            mode.reg_idx = IDX_EX;
                        end
                        3'd6: mode.uses_next = 1'b1;
                        default: begin
                            mode.uses_next  = 1'b1;
                            mode.addr_is_pc = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/opnd_loc_calc.sv
// Computes the location value and the updated PC and SP from a mode record.
// Assumes the extension word arrives combinationally for address pc.
module opnd_loc_calc
    import opnd_pkg::*;
(
    input  mode_t              mode,
    input  logic [WORD_W-1:0]  pc,
    input  logic [WORD_W-1:0]  sp,
    input  logic [WORD_W-1:0]  gpr_val,
    input  logic [WORD_W-1:0]  next_word,
    output logic [WORD_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  loc_value,
    output logic [WORD_W-1:0]  pc_next,
    output logic [WORD_W-1:0]  sp_next
);
    logic [WORD_W-1:0] sp_dec, sp_inc, sp_eff, base, offset, addr;

    assign rd_addr = pc;

    // Form the effective memory address from base and optional offset.
    always_comb begin
        sp_dec = sp - WORD_W'(1);
        sp_inc = sp + WORD_W'(1);
        sp_eff = mode.sp_pre_dec ? sp_dec : sp;
        case (mode.base)
            BASE_GPR: base = gpr_val;
            BASE_SP:  base = sp_eff;
            default:  base = '0;
        endcase
        offset = mode.uses_next ? next_word : '0;
        addr   = mode.addr_is_pc ? pc : base + offset;
    end

    // Select the reported value by location kind.
    always_comb begin
        case (mode.kind)
            LOC_REG: loc_value = WORD_W'(mode.reg_idx);
            LOC_MEM: loc_value = addr;
            default: loc_value = mode.lit;
        endcase
    end

    // Side effects on the working pointers.
    always_comb begin
        pc_next = pc + WORD_W'(mode.uses_next);
        if (mode.sp_pre_dec)       sp_next = sp_dec;
        else if (mode.sp_post_inc) sp_next = sp_inc;
        else                       sp_next = sp;
    end
endmodule

// File: rtl/opnd_resolver.sv
// Top: resolves one operand per request and registers the result.
// Assumes mem_rdata is a combinational function of mem_addr.
module opnd_resolver
    import opnd_pkg::*;
#(
    parameter int NUM_GPR = 8,
    parameter int DW      = WORD_W,
    localparam int GIW    = $clog2(NUM_GPR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [CODE_W-1:0]   op_code,
    input  logic                is_a,
    input  logic [DW-1:0]       pc_in,
    input  logic [DW-1:0]       sp_in,
    input  logic [NUM_GPR*DW-1:0] gpr_flat,
    output logic [DW-1:0]       mem_addr,
    input  logic [DW-1:0]       mem_rdata,
    output logic                res_valid,
    output logic [1:0]          loc_kind,
    output logic [DW-1:0]       loc_value,
    output logic                writable,
    output logic [DW-1:0]       pc_out,
    output logic [DW-1:0]       sp_out,
    output logic                err
);
    mode_t         mode;
    logic [DW-1:0] gpr [NUM_GPR];
    logic [DW-1:0] gpr_val, val_c, pc_c, sp_c;

    // Unpack the flat register bus.
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
        assign gpr[g] = gpr_flat[g*DW +: DW];
    end
    assign gpr_val = gpr[mode.reg_idx[GIW-1:0]];

    opnd_mode_decode u_dec (
        .code (op_code),
        .is_a (is_a),
        .mode (mode)
    );

    opnd_loc_calc u_calc (
        .mode      (mode),
        .pc        (pc_in),
        .sp        (sp_in),
        .gpr_val   (gpr_val),
        .next_word (mem_rdata),
        .rd_addr   (mem_addr),
        .loc_value (val_c),
        .pc_next   (pc_c),
        .sp_next   (sp_c)
    );

    // Register the resolved location on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            loc_kind  <= '0;
            loc_value <= '0;
            writable  <= 1'b0;
            pc_out    <= '0;
            sp_out    <= '0;
            err       <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                loc_kind  <= mode.kind;
                loc_value <= val_c;
                writable  <= (mode.kind != LOC_LIT);
                pc_out    <= pc_c;
                sp_out    <= sp_c;
                err       <= mode.illegal;
            end
        end
    end

    // Literal locations never accept writes.
    assert_lit_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && loc_kind == 2'd2 |-> !writable);

    // An illegal selector leaves both pointers as presented.
    assert_err_keeps_ptrs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) || req_valid |=> (err && res_valid) ->
            (pc_out == $past(pc_in) && sp_out == $past(sp_in)));

    // Errors only arise from side-b literal-range selectors.
    assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> err == (!$past(is_a) && $past(op_code) >= 6'h20));

    // PC advances by at most one word per operand.
    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (pc_out == $past(pc_in)) || (pc_out == $past(pc_in) + 16'd1));

    // SP moves by at most one, and only for the stack selector.
    assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && op_code != 6'h18 |=> sp_out == $past(sp_in));

    // A result is flagged only after a request.
    assert_valid_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
endmodule

// File: tb/opnd_resolver_test.sv
module opnd_resolver_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [5:0]   op_code = '0;
    logic         is_a = 1'b0;
    logic [15:0]  pc_in = '0, sp_in = '0;
    logic [127:0] gpr_flat = '0;
    logic [15:0]  mem_addr, mem_rdata;
    logic         res_valid, writable, err;
    logic [1:0]   loc_kind;
    logic [15:0]  loc_value, pc_out, sp_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    // Memory model: a word pattern that makes offset sums carry.
    function automatic logic [15:0] mem_f(input logic [15:0] a);
        return a * 16'd37 + 16'hF0B1;
    endfunction
    assign mem_rdata = mem_f(mem_addr);

    opnd_resolver uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_code(op_code),
        .is_a(is_a), .pc_in(pc_in), .sp_in(sp_in), .gpr_flat(gpr_flat),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .res_valid(res_valid),
        .loc_kind(loc_kind), .loc_value(loc_value), .writable(writable),
        .pc_out(pc_out), .sp_out(sp_out), .err(err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] gpr_of(input int i);
        return gpr_flat[i*16 +: 16];
    endfunction

    // Reference model written from the requirements.
    task automatic resolve(input int code, input bit a,
                           output string tag, output logic [1:0] k,
                           output logic [15:0] v, output bit w,
                           output logic [15:0] p, output logic [15:0] s,
                           output bit e);
        logic [15:0] nw;
        nw = mem_f(pc_in);
        k = 2'd1; v = 16'h0; w = 1'b1; p = pc_in; s = sp_in; e = 1'b0;
        if (code < 8) begin
            tag = "R1"; k = 2'd0; v = 16'(code);
        end else if (code < 16) begin
            tag = "R2"; v = gpr_of(code - 8);
        end else if (code < 24) begin
            tag = "R3"; v = gpr_of(code - 16) + nw; p = pc_in + 16'd1;
        end else if (code == 24) begin
            tag = "R4";
            if (a) begin v = sp_in; s = sp_in + 16'd1; end
            else begin v = sp_in - 16'd1; s = sp_in - 16'd1; end
        end else if (code == 25) begin
            tag = "R5"; v = sp_in;
        end else if (code == 26) begin
            tag = "R5"; v = sp_in + nw; p = pc_in + 16'd1;
        end else if (code < 30) begin
            tag = "R6"; k = 2'd0; v = 16'(code - 27 + 8);
        end else if (code == 30) begin
            tag = "R7"; v = nw; p = pc_in + 16'd1;
        end else if (code == 31) begin
            tag = "R7"; v = pc_in; p = pc_in + 16'd1;
        end else if (a) begin
            tag = "R8"; k = 2'd2; v = 16'(code) - 16'h21; w = 1'b0;
        end else begin
            tag = "R10"; k = 2'd2; v = 16'h0; w = 1'b0; e = 1'b1;
        end
    endtask

    task automatic run_case(input int code, input bit a);
        string tag;
        logic [1:0] k;
        logic [15:0] v, p, s;
        bit w, e;
        @(negedge clk);
        op_code = 6'(code); is_a = a; req_valid = 1'b1;
        #0.5;
        resolve(code, a, tag, k, v, w, p, s, e);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk("R11", "res_valid", 16'(res_valid), 16'h1);
        chk(tag, "loc_kind", 16'(loc_kind), 16'(k));
        chk(tag, "loc_value", loc_value, v);
        chk(w ? tag : "R9", "writable", 16'(writable), 16'(w));
        chk(tag, "pc_out", pc_out, p);
        chk(tag, "sp_out", sp_out, s);
        chk(e ? "R10" : tag, "err", 16'(err), 16'(e));
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset res_valid", 16'(res_valid), 16'h0);
        chk("R11", "reset loc_value", loc_value, 16'h0);
        chk("R11", "reset pc_out", pc_out, 16'h0);
        chk("R11", "reset err", 16'(err), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int st = 0; st < 3; st++) begin
            case (st)
                0: begin pc_in = 16'h1000; sp_in = 16'h8000; end
                1: begin pc_in = 16'hFFFF; sp_in = 16'h0000; end
                default: begin pc_in = 16'h0001; sp_in = 16'hFFFF; end
            endcase
            for (int g = 0; g < 8; g++)
                gpr_flat[g*16 +: 16] = (st == 1) ? 16'hFFF0 + 16'(g)
                                                 : 16'h0101 * 16'(g + 1 + st * 7);
            for (int c = 0; c < 64; c++) begin
                run_case(c, 1'b1);
                run_case(c, 1'b0);
            end
        end
        // Idle cycle: no request, no fresh result (R11).
        @(negedge clk);
        @(posedge clk);
        #1;
        chk("R11", "idle res_valid", 16'(res_valid), 16'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule